// File: doc/BRIEF.md
# Auxiliary System Control Registers

This block gathers the small control registers a system board needs around its processor: a configuration byte, a diagnostic byte, a modem-control byte, two auxiliary bytes, a 16-bit diagnostic LED word and a 32-bit system-control word. A host reaches them over a single-cycle register port. Each register has its own select line, and a write strobe applies the write on the next rising clock edge. Reads are combinational and zero-extended to the bus width.

Several registers act on the system instead of only storing data. The second auxiliary register holds a power-fail status bit. That bit follows an external power-failing input only while the interrupt enable in the configuration byte is set, and software clears it with a write. The same register carries a power-off request. A bit in the first auxiliary register fires a terminal-count strobe toward a floppy controller, and the system-control word issues a system-reset request. A registered interrupt output reports the power-fail status.

Two resets exist. The ordinary block reset leaves the diagnostic byte, the LED word and the system-control word intact. A separate power-on reset clears everything.

Top module: `aux_sysctl`

## Requirements
- R1: Select bit positions are 0 configuration, 1 diagnostic, 2 modem, 3 aux-one, 4 aux-two, 5 LED, 6 system-control. The configuration, diagnostic and modem bytes and the 16-bit LED word store written data unchanged, truncated to their width. Reads return the selected register zero-extended, and return 0 when no select is active.
- R2: `pf_irq` is high exactly one cycle after aux-two bit 5 and configuration bit 3 are both 1.
- R3: When the sampled `pwr_failing` level differs from the previous sample, aux-two bit 5 becomes the new level ANDed with configuration bit 3. Without such a change the bit holds its value, including when configuration bit 3 changes.
- R4: An aux-two write stores data bits 0 and 1 with the current bit 5. All other bits are stored as 0.
- R5: An aux-two write with data bit 1 set stores only data bit 0. Bit 5 and bit 1 then read 0.
- R6: An aux-two write with data bit 0 set raises `pwr_off_req` for exactly the one cycle after the write edge.
- R7: An aux-one write stores the data with bit 1 forced to 0. If data bit 1 was set, `tc_strobe` is high for exactly one cycle after the write edge.
- R8: A system-control write at offset 0 with bit 0 set loads the value 0x02 and raises `sys_rst_req` for one cycle. Other writes to it have no effect, reads at a nonzero offset return 0, and its value is only ever 0 or 0x02.
- R9: `rst` clears the configuration, modem, aux-one and aux-two registers, `pf_irq` and the request pulses. It leaves the diagnostic, LED and system-control registers unchanged.
- R10: `por` clears every register, including the diagnostic, LED and system-control registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous block reset, active high |
| por | input | 1 | Synchronous power-on reset, active high |
| reg_sel | input | 7 | One-hot register select |
| wr_en | input | 1 | Write strobe for the selected register |
| offset | input | 2 | Byte offset inside the system-control word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the selected register |
| pwr_failing | input | 1 | External power-failing level |
| pf_irq | output | 1 | Power-fail interrupt |
| tc_strobe | output | 1 | Terminal-count pulse |
| pwr_off_req | output | 1 | Power-off request pulse |
| sys_rst_req | output | 1 | System-reset request pulse |

## Verification
The bench targets the guarded, sticky power-fail bit. A power failure seen while the interrupt is disabled must not be set later when software enables the interrupt. A design that tracked the live input level would raise a spurious interrupt at that point. The bench also writes aux-two with both low bits set and checks that the status clears and bit 1 reads back 0. It checks that the strobe bits of aux-one and system-control never read back as stored ones, which would catch a plain register. Finally it applies the block reset after loading every register, so a design that clears the diagnostic, LED or system-control register, or keeps the configuration byte, fails the readback.

// File: rtl/aux_sysctl_pkg.sv
package aux_sysctl_pkg;

    localparam int BYTE_W  = 8;
    localparam int NUM_SEL = 7;

    localparam int SEL_CFG   = 0;
    localparam int SEL_DIAG  = 1;
    localparam int SEL_MODEM = 2;
    localparam int SEL_AUX1  = 3;
    localparam int SEL_AUX2  = 4;
    localparam int SEL_LED   = 5;
    localparam int SEL_SYS   = 6;

    localparam int CFG_IRQ_EN_BIT = 3;
    localparam int AUX1_TC_BIT    = 1;
    localparam int SYS_GO_BIT     = 0;

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t SYS_RESET_STAT = 8'h02;

    typedef struct packed {
        logic [1:0] spare_hi;
        logic       pf;
        logic [2:0] spare_mid;
        logic       int_clr;
        logic       pwr_off;
    } aux2_t;

    function automatic aux2_t aux2_update(aux2_t cur, logic we, byte_t wd, logic pf_new);
        aux2_t n;
        aux2_t w;
        w = aux2_t'(wd);
        n = cur;
        n.pf = pf_new;
        if (we) begin
            n         = '0;
            n.pwr_off = w.pwr_off;
            n.int_clr = w.int_clr;
            n.pf      = pf_new;
            if (w.int_clr) begin
                n.int_clr = 1'b0;
                n.pf      = 1'b0;
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/aux_plain_reg.sv
module aux_plain_reg #(
    parameter int W           = 8,
    parameter bit KEEP_ON_RST = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         por,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (KEEP_ON_RST) begin : g_keep
            always_ff @(posedge clk) begin
                if (por)     q <= '0;
                else if (we) q <= d;
            end
        end else begin : g_clear
            always_ff @(posedge clk) begin
                if (por || rst) q <= '0;
                else if (we)    q <= d;
            end
        end
    endgenerate

    logic por_seen;
    always_ff @(posedge clk) begin
        if (por) por_seen <= 1'b1;
    end

    // R1
    store_chk: assert property (@(posedge clk)
        disable iff (por || rst || (por_seen !== 1'b1))
        we |=> q == $past(d));

endmodule

// File: rtl/aux_power_ctrl.sv
module aux_power_ctrl
    import aux_sysctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  por,
    input  logic  cfg_en,
    input  logic  we,
    input  byte_t wd,
    input  logic  pf_in,
    output byte_t aux2_q,
    output logic  irq,
    output logic  pwr_off_req
);

    aux2_t aux2_r;
    aux2_t aux2_nxt;
    logic  pf_prev;
    logic  pf_new;

    always_comb begin
        pf_new   = (pf_in != pf_prev) ? (pf_in & cfg_en) : aux2_r.pf;
        aux2_nxt = aux2_update(aux2_r, we, wd, pf_new);
    end

    always_ff @(posedge clk) begin
        if (por || rst) begin
            aux2_r      <= '0;
            pf_prev     <= 1'b0;
            irq         <= 1'b0;
            pwr_off_req <= 1'b0;
        end else begin
            pf_prev     <= pf_in;
            aux2_r      <= aux2_nxt;
            irq         <= aux2_r.pf & cfg_en;
            pwr_off_req <= we & wd[0];
        end
    end

    assign aux2_q = byte_t'(aux2_r);

    logic armed;
    always_ff @(posedge clk) begin
        if (por || rst) armed <= 1'b0;
        else            armed <= 1'b1;
    end

    // R2
    irq_follow_chk: assert property (@(posedge clk)
        disable iff (por || rst || !armed)
        irq == $past(aux2_q[5] & cfg_en));

    // R3
    pf_sticky_chk: assert property (@(posedge clk)
        disable iff (por || rst || !armed)
        (!we && (pf_in == pf_prev)) |=> $stable(aux2_q[5]));

    // R5
    int_clr_chk: assert property (@(posedge clk)
        disable iff (por || rst || !armed)
        (we && wd[1]) |=> (aux2_q[5] == 1'b0) && (aux2_q[1] == 1'b0));

    // R6
    pwr_off_chk: assert property (@(posedge clk)
        disable iff (por || rst || !armed)
        (we && wd[0]) |=> (pwr_off_req && aux2_q[0]));

endmodule

// File: rtl/aux_strobe_regs.sv
module aux_strobe_regs
    import aux_sysctl_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por,
    input  logic              aux1_we,
    input  byte_t             aux1_wd,
    input  logic              sys_we,
    input  logic              sys_go,
    output byte_t             aux1_q,
    output logic              tc_strobe,
    output logic [WORD_W-1:0] sys_q,
    output logic              sys_rst_req
);

    localparam int PAD_W = WORD_W - BYTE_W;
    localparam logic [WORD_W-1:0] SYS_LOAD = {{PAD_W{1'b0}}, SYS_RESET_STAT};

    byte_t aux1_masked;

    always_comb begin
        aux1_masked              = aux1_wd;
        aux1_masked[AUX1_TC_BIT] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (por || rst) begin
            aux1_q      <= '0;
            tc_strobe   <= 1'b0;
            sys_rst_req <= 1'b0;
        end else begin
            if (aux1_we) aux1_q <= aux1_masked;
            tc_strobe   <= aux1_we & aux1_wd[AUX1_TC_BIT];
            sys_rst_req <= sys_we & sys_go;
        end
    end

    always_ff @(posedge clk) begin
        if (por)                   sys_q <= '0;
        else if (sys_we && sys_go) sys_q <= SYS_LOAD;
    end

    logic armed;
    logic por_seen;
    always_ff @(posedge clk) begin
        if (por || rst) armed <= 1'b0;
        else            armed <= 1'b1;
        if (por)        por_seen <= 1'b1;
    end

    // R7
    tc_chk: assert property (@(posedge clk)
        disable iff (por || rst || !armed)
        (aux1_we && aux1_wd[AUX1_TC_BIT]) |=> (tc_strobe && !aux1_q[AUX1_TC_BIT]));

    // R8
    sys_val_chk: assert property (@(posedge clk)
        disable iff (por || (por_seen !== 1'b1))
        (sys_q == '0) || (sys_q == SYS_LOAD));

    // R8
    sys_req_chk: assert property (@(posedge clk)
        disable iff (por || rst || !armed || (por_seen !== 1'b1))
        sys_rst_req |-> (sys_q == SYS_LOAD));

endmodule

// File: rtl/aux_sysctl.sv
module aux_sysctl
    import aux_sysctl_pkg::*;
#(
    parameter int LED_W  = 16,
    parameter int WORD_W = 32,
    parameter int OFS_W  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               por,
    input  logic [NUM_SEL-1:0] reg_sel,
    input  logic               wr_en,
    input  logic [OFS_W-1:0]   offset,
    input  logic [WORD_W-1:0]  wdata,
    output logic [WORD_W-1:0]  rdata,
    input  logic               pwr_failing,
    output logic               pf_irq,
    output logic               tc_strobe,
    output logic               pwr_off_req,
    output logic               sys_rst_req
);

    localparam int BPAD_W = WORD_W - BYTE_W;
    localparam int LPAD_W = WORD_W - LED_W;

    logic [NUM_SEL-1:0] we;
    logic               ofs_zero;
    byte_t              wbyte;

    byte_t              cfg_q;
    byte_t              diag_q;
    byte_t              modem_q;
    byte_t              aux1_q;
    byte_t              aux2_q;
    logic [LED_W-1:0]   led_q;
    logic [WORD_W-1:0]  sys_q;

    assign we       = reg_sel & {NUM_SEL{wr_en}};
    assign ofs_zero = (offset == '0);
    assign wbyte    = wdata[BYTE_W-1:0];

    aux_plain_reg #(.W(BYTE_W), .KEEP_ON_RST(1'b0)) u_cfg (
        .clk(clk), .rst(rst), .por(por), .we(we[SEL_CFG]), .d(wbyte), .q(cfg_q));

    aux_plain_reg #(.W(BYTE_W), .KEEP_ON_RST(1'b1)) u_diag (
        .clk(clk), .rst(rst), .por(por), .we(we[SEL_DIAG]), .d(wbyte), .q(diag_q));

    aux_plain_reg #(.W(BYTE_W), .KEEP_ON_RST(1'b0)) u_modem (
        .clk(clk), .rst(rst), .por(por), .we(we[SEL_MODEM]), .d(wbyte), .q(modem_q));

    aux_plain_reg #(.W(LED_W), .KEEP_ON_RST(1'b1)) u_led (
        .clk(clk), .rst(rst), .por(por), .we(we[SEL_LED]),
        .d(wdata[LED_W-1:0]), .q(led_q));

    aux_power_ctrl u_pwr (
        .clk(clk), .rst(rst), .por(por),
        .cfg_en(cfg_q[CFG_IRQ_EN_BIT]),
        .we(we[SEL_AUX2]), .wd(wbyte), .pf_in(pwr_failing),
        .aux2_q(aux2_q), .irq(pf_irq), .pwr_off_req(pwr_off_req));

    aux_strobe_regs #(.WORD_W(WORD_W)) u_strb (
        .clk(clk), .rst(rst), .por(por),
        .aux1_we(we[SEL_AUX1]), .aux1_wd(wbyte),
        .sys_we(we[SEL_SYS] & ofs_zero), .sys_go(wdata[SYS_GO_BIT]),
        .aux1_q(aux1_q), .tc_strobe(tc_strobe),
        .sys_q(sys_q), .sys_rst_req(sys_rst_req));

    always_comb begin
        rdata = '0;
        if (reg_sel[SEL_CFG])   rdata = rdata | {{BPAD_W{1'b0}}, cfg_q};
        if (reg_sel[SEL_DIAG])  rdata = rdata | {{BPAD_W{1'b0}}, diag_q};
        if (reg_sel[SEL_MODEM]) rdata = rdata | {{BPAD_W{1'b0}}, modem_q};
        if (reg_sel[SEL_AUX1])  rdata = rdata | {{BPAD_W{1'b0}}, aux1_q};
        if (reg_sel[SEL_AUX2])  rdata = rdata | {{BPAD_W{1'b0}}, aux2_q};
        if (reg_sel[SEL_LED])   rdata = rdata | {{LPAD_W{1'b0}}, led_q};
        if (reg_sel[SEL_SYS] && ofs_zero) rdata = rdata | sys_q;
    end

    // R1
    idle_read_chk: assert property (@(posedge clk)
        disable iff (por || rst)
        (reg_sel == '0) |-> (rdata == '0));

endmodule

// File: tb/tb_aux_sysctl.sv
module tb_aux_sysctl;

    localparam int CLK_PERIOD = 10;
    localparam int S_CFG = 0, S_DIAG = 1, S_MODEM = 2, S_AUX1 = 3,
                   S_AUX2 = 4, S_LED = 5, S_SYS = 6;

    logic        clk = 1'b0;
    logic        rst, por, wr_en, pwr_failing;
    logic [6:0]  reg_sel;
    logic [1:0]  offset;
    logic [31:0] wdata, rdata;
    logic        pf_irq, tc_strobe, pwr_off_req, sys_rst_req;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aux_sysctl dut (
        .clk(clk), .rst(rst), .por(por), .reg_sel(reg_sel), .wr_en(wr_en),
        .offset(offset), .wdata(wdata), .rdata(rdata), .pwr_failing(pwr_failing),
        .pf_irq(pf_irq), .tc_strobe(tc_strobe), .pwr_off_req(pwr_off_req),
        .sys_rst_req(sys_rst_req));

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic do_write(input int idx, input logic [1:0] ofs, input logic [31:0] d);
        @(negedge clk);
        reg_sel = 7'(1 << idx);
        wr_en   = 1'b1;
        offset  = ofs;
        wdata   = d;
        @(negedge clk);
        reg_sel = '0;
        wr_en   = 1'b0;
        offset  = '0;
    endtask

    task automatic do_read(input int idx, input logic [1:0] ofs, output logic [31:0] v);
        reg_sel = 7'(1 << idx);
        offset  = ofs;
        #1;
        v = rdata;
        reg_sel = '0;
        offset  = '0;
        #1;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        do_read(S_CFG, 0, v);  chk("R10 cfg after por", v, 0);
        do_read(S_DIAG, 0, v); chk("R10 diag after por", v, 0);
        do_read(S_SYS, 0, v);  chk("R10 sys after por", v, 0);
        do_read(S_LED, 0, v);  chk("R10 led after por", v, 0);
        chk("R2 irq after por", {31'b0, pf_irq}, 0);
    endtask

    task automatic t_plain_regs();
        logic [31:0] v;
        do_write(S_CFG, 0, 32'h0000_00F0);   do_read(S_CFG, 0, v);   chk("R1 cfg", v, 32'hF0);
        do_write(S_DIAG, 0, 32'hDEAD_BE5A);  do_read(S_DIAG, 0, v);  chk("R1 diag", v, 32'h5A);
        do_write(S_MODEM, 0, 32'h0000_0181); do_read(S_MODEM, 0, v); chk("R1 modem", v, 32'h81);
        do_write(S_LED, 0, 32'hFFFF_1234);   do_read(S_LED, 0, v);   chk("R1 led", v, 32'h1234);
        reg_sel = '0; #1;
        chk("R1 idle read", rdata, 0);
        do_write(S_CFG, 0, 0);
    endtask

    task automatic t_power_fail();
        logic [31:0] v;
        do_write(S_CFG, 0, 32'h08);
        pwr_failing = 1'b1;
        @(negedge clk);
        do_read(S_AUX2, 0, v); chk("R3 pf set", v, 32'h20);
        chk("R2 irq latency", {31'b0, pf_irq}, 0);
        @(negedge clk);
        chk("R2 irq high", {31'b0, pf_irq}, 1);
        do_write(S_AUX2, 0, 32'hFD);
        do_read(S_AUX2, 0, v); chk("R4 merge", v, 32'h21);
        chk("R6 pwr_off pulse", {31'b0, pwr_off_req}, 1);
        @(negedge clk);
        chk("R6 pwr_off one cycle", {31'b0, pwr_off_req}, 0);
        do_write(S_AUX2, 0, 32'hFC);
        do_read(S_AUX2, 0, v); chk("R4 keep pf", v, 32'h20);
        chk("R6 no pwr_off", {31'b0, pwr_off_req}, 0);
        do_write(S_CFG, 0, 0);
        chk("R2 irq lag on disable", {31'b0, pf_irq}, 1);
        @(negedge clk);
        chk("R2 irq low", {31'b0, pf_irq}, 0);
        do_read(S_AUX2, 0, v); chk("R3 sticky over cfg", v, 32'h20);
        do_write(S_AUX2, 0, 32'h03);
        do_read(S_AUX2, 0, v); chk("R5 clear", v, 32'h01);
        chk("R6 pwr_off on clear", {31'b0, pwr_off_req}, 1);
        pwr_failing = 1'b0;
        @(negedge clk);
        pwr_failing = 1'b1;
        @(negedge clk);
        do_read(S_AUX2, 0, v); chk("R3 guarded", v, 32'h01);
        do_write(S_CFG, 0, 32'h08);
        @(negedge clk);
        do_read(S_AUX2, 0, v); chk("R3 no set on enable", v, 32'h01);
        chk("R2 no irq", {31'b0, pf_irq}, 0);
        pwr_failing = 1'b0;
        @(negedge clk);
        pwr_failing = 1'b1;
        @(negedge clk);
        do_read(S_AUX2, 0, v); chk("R3 set on edge", v, 32'h21);
        pwr_failing = 1'b0;
        @(negedge clk);
        do_read(S_AUX2, 0, v); chk("R3 clear on fall", v, 32'h01);
        do_write(S_CFG, 0, 0);
    endtask

    task automatic t_aux1();
        logic [31:0] v;
        do_write(S_AUX1, 0, 32'hFF);
        chk("R7 tc pulse", {31'b0, tc_strobe}, 1);
        do_read(S_AUX1, 0, v); chk("R7 bit1 masked", v, 32'hFD);
        @(negedge clk);
        chk("R7 tc one cycle", {31'b0, tc_strobe}, 0);
        do_write(S_AUX1, 0, 32'h5C);
        chk("R7 no tc", {31'b0, tc_strobe}, 0);
        do_read(S_AUX1, 0, v); chk("R7 store", v, 32'h5C);
    endtask

    task automatic t_sysctl();
        logic [31:0] v;
        do_write(S_SYS, 0, 32'hFFFF_FFFE);
        chk("R8 no req bit0 clear", {31'b0, sys_rst_req}, 0);
        do_read(S_SYS, 0, v); chk("R8 unchanged", v, 0);
        do_write(S_SYS, 2, 32'h1);
        chk("R8 no req off offset", {31'b0, sys_rst_req}, 0);
        do_read(S_SYS, 0, v); chk("R8 ignored offset", v, 0);
        do_write(S_SYS, 0, 32'h1);
        chk("R8 req pulse", {31'b0, sys_rst_req}, 1);
        do_read(S_SYS, 0, v); chk("R8 stat", v, 32'h02);
        do_read(S_SYS, 1, v); chk("R8 offset read zero", v, 0);
        @(negedge clk);
        chk("R8 req one cycle", {31'b0, sys_rst_req}, 0);
    endtask

    task automatic t_selective_reset();
        logic [31:0] v;
        do_write(S_CFG, 0, 32'h08);
        do_write(S_DIAG, 0, 32'hA5);
        do_write(S_MODEM, 0, 32'h3C);
        do_write(S_AUX1, 0, 32'h81);
        do_write(S_AUX2, 0, 32'h01);
        do_write(S_LED, 0, 32'hBEEF);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        do_read(S_CFG, 0, v);   chk("R9 cfg cleared", v, 0);
        do_read(S_MODEM, 0, v); chk("R9 modem cleared", v, 0);
        do_read(S_AUX1, 0, v);  chk("R9 aux1 cleared", v, 0);
        do_read(S_AUX2, 0, v);  chk("R9 aux2 cleared", v, 0);
        do_read(S_DIAG, 0, v);  chk("R9 diag kept", v, 32'hA5);
        do_read(S_LED, 0, v);   chk("R9 led kept", v, 32'hBEEF);
        do_read(S_SYS, 0, v);   chk("R9 sys kept", v, 32'h02);
    endtask

    task automatic t_por();
        logic [31:0] v;
        @(negedge clk); por = 1'b1;
        @(negedge clk); por = 1'b0;
        do_read(S_DIAG, 0, v); chk("R10 diag cleared", v, 0);
        do_read(S_LED, 0, v);  chk("R10 led cleared", v, 0);
        do_read(S_SYS, 0, v);  chk("R10 sys cleared", v, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; por = 1'b1; wr_en = 1'b0; pwr_failing = 1'b0;
        reg_sel = '0; offset = '0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0; por = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_plain_regs();
        t_power_fail();
        t_aux1();
        t_sysctl();
        t_selective_reset();
        t_por();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule